// File: doc/BRIEF.md
# Branch and Jump Next-PC Resolver

This combinational unit decides where a 32-bit load/store processor fetches next. Each cycle it receives the program counter of the instruction being resolved, the raw instruction word and the two source register values read for it. It reports the next fetch address, whether control flow leaves the sequential path, and whether a return address has to be written to the register file, together with the register index and the value to write.

Conditional branches carry a signed 16-bit displacement counted in instruction words from the following instruction. Absolute jumps carry a 26-bit word index that replaces the low bits of the following instruction's address, keeping its top four bits. Register jumps take their target from the first source operand. Branches that link write the return address only when the branch is taken. Jumps that link always write it. Any word this unit does not recognise falls through to PC+4. The processor places the unit between register read and the fetch address multiplexer. It has no state, so the outputs follow the inputs within the same cycle.

Top module: `bru_next_pc`

## Requirements
- R1: For any instruction outside the recognised set, and for a conditional branch whose condition is false, `next_pc_o` equals `pc_i`+4, `taken_o` is 0 and `link_we_o` is 0. Words that fall through include opcode 8 and REGIMM (opcode 1) with rt field 2.
- R2: A taken conditional branch targets `pc_i`+4 plus the sign-extended `instr_i[15:0]` shifted left by two. A displacement of 0 therefore gives `pc_i`+4 with `taken_o`=1, 0xFFFF gives `pc_i`, and 0x8000 gives `pc_i`+4−131072.
- R3: Opcode 4 is taken when the two operands are equal. Opcode 5 is taken when they differ.
- R4: Comparisons with zero treat `rs_val_i` as signed. The cases are opcode 6 (≤0), opcode 7 (>0), and opcode 1 with rt field 0 (<0) or rt field 1 (≥0).
- R5: Opcode 1 with rt field 16 (<0) or 17 (≥0) branches like R4. When taken it raises `link_we_o` with `link_idx_o`=31. When not taken it writes nothing.
- R6: Opcode 2 and opcode 3 are always taken to {(`pc_i`+4)[31:28], `instr_i[25:0]`, 2'b00}. Opcode 3 also links into register 31.
- R7: Opcode 0 with funct (`instr_i[5:0]`) 8 jumps to `rs_val_i` without linking. Funct 9 jumps to `rs_val_i` and links into the register named by `instr_i[15:11]`.
- R8: `link_addr_o` is always `pc_i`+4, and `link_we_o` is never 1 while `taken_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the instruction being resolved |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named by bits 25:21 |
| rt_val_i | input | 32 | Value of the register named by bits 20:16 |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Return address must be written |
| link_idx_o | output | 5 | Destination register of the link write |
| link_addr_o | output | 32 | Return address (PC+4) |

## Verification
The bound checker tests, on every input change, the invariants that hold for any operands. A path not taken falls through with no link. A link write comes only with a taken path and always carries PC+4. An and-link branch links into register 31. Absolute jumps stay inside the 256 MB region of PC+4 and are word aligned. The equality branch follows operand equality, and a register jump goes to the operand. The exact displacement arithmetic, the signed treatment of the values 0, 1, −1, 0x7FFFFFFF and 0x80000000, the choice of the named link register, and the fall-through of unrecognised words are shown only by the bench's directed scenarios, which compare full expected addresses.

// File: rtl/bru_pkg.sv
package bru_pkg;

   localparam logic [5:0] OP_SPECIAL = 6'd0;
   localparam logic [5:0] OP_REGIMM  = 6'd1;
   localparam logic [5:0] OP_J       = 6'd2;
   localparam logic [5:0] OP_JAL     = 6'd3;
   localparam logic [5:0] OP_BEQ     = 6'd4;
   localparam logic [5:0] OP_BNE     = 6'd5;
   localparam logic [5:0] OP_BLEZ    = 6'd6;
   localparam logic [5:0] OP_BGTZ    = 6'd7;

   localparam logic [4:0] RI_LTZ     = 5'd0;
   localparam logic [4:0] RI_GEZ     = 5'd1;
   localparam logic [4:0] RI_LTZ_LNK = 5'd16;
   localparam logic [4:0] RI_GEZ_LNK = 5'd17;

   localparam logic [5:0] FN_JREG    = 6'd8;
   localparam logic [5:0] FN_JREG_LK = 6'd9;

   typedef enum logic [3:0] {
      K_NONE, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ,
      K_LTZ_LK, K_GEZ_LK, K_JABS, K_JABS_LK, K_JREG, K_JREG_LK
   } bru_kind_e;

   typedef enum logic [1:0] {
      SRC_SEQ, SRC_DISP, SRC_ABS, SRC_REG
   } bru_src_e;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
   import bru_pkg::*;
(
   input  logic [31:0] instr_i,
   output bru_kind_e   kind_o,
   output logic [4:0]  rd_o
);
   logic [5:0] op;
   logic [4:0] rt_f;
   logic [5:0] fn;
   logic       unused_bits;

   assign op          = instr_i[31:26];
   assign rt_f        = instr_i[20:16];
   assign fn          = instr_i[5:0];
   assign rd_o        = instr_i[15:11];
   assign unused_bits = ^{instr_i[25:21], instr_i[10:6]};

   always_comb begin
      kind_o = K_NONE;
      unique case (op)
         OP_BEQ:  kind_o = K_EQ;
         OP_BNE:  kind_o = K_NE;
         OP_BLEZ: kind_o = K_LEZ;
         OP_BGTZ: kind_o = K_GTZ;
         OP_J:    kind_o = K_JABS;
         OP_JAL:  kind_o = K_JABS_LK;
         OP_REGIMM: begin
            case (rt_f)
               RI_LTZ:     kind_o = K_LTZ;
               RI_GEZ:     kind_o = K_GEZ;
               RI_LTZ_LNK: kind_o = K_LTZ_LK;
               RI_GEZ_LNK: kind_o = K_GEZ_LK;
               default:    kind_o = K_NONE;
            endcase
         end
         OP_SPECIAL: begin
            case (fn)
               FN_JREG:    kind_o = K_JREG;
               FN_JREG_LK: kind_o = K_JREG_LK;
               default:    kind_o = K_NONE;
            endcase
         end
         default: kind_o = K_NONE;
      endcase
   end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
   import bru_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit FAST_ZERO = 1'b1
) (
   input  bru_kind_e        kind_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   output logic             taken_o
);
   logic neg, zero;

   generate
      if (FAST_ZERO) begin : g_fast
         assign neg  = a_i[XLEN-1];
         assign zero = ~|a_i;
      end else begin : g_cmp
         assign neg  = $signed(a_i) < 0;
         assign zero = a_i == '0;
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         K_EQ:                 taken_o = a_i == b_i;
         K_NE:                 taken_o = a_i != b_i;
         K_LEZ:                taken_o = neg | zero;
         K_GTZ:                taken_o = ~neg & ~zero;
         K_LTZ, K_LTZ_LK:      taken_o = neg;
         K_GEZ, K_GEZ_LK:      taken_o = ~neg;
         K_JABS, K_JABS_LK,
         K_JREG, K_JREG_LK:    taken_o = 1'b1;
         default:              taken_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16,
   parameter int JIDX_W = 26
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [JIDX_W-1:0] field_i,
   input  logic [XLEN-1:0]   reg_i,
   output logic [XLEN-1:0]   seq_o,
   output logic [XLEN-1:0]   disp_o,
   output logic [XLEN-1:0]   abs_o,
   output logic [XLEN-1:0]   reg_o
);
   localparam int EXT_W = XLEN - DISP_W - 2;
   localparam int REG_W = XLEN - JIDX_W - 2;

   logic [DISP_W-1:0] disp;
   logic [XLEN-1:0]   disp_bytes;

   assign disp       = field_i[DISP_W-1:0];
   assign seq_o      = pc_i + XLEN'(4);
   assign disp_bytes = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   assign disp_o     = seq_o + disp_bytes;
   assign reg_o      = reg_i;

   generate
      if (REG_W > 0) begin : g_region
         assign abs_o = {seq_o[XLEN-1 -: REG_W], field_i, 2'b00};
      end else begin : g_flat
         assign abs_o = {field_i, 2'b00};
      end
   endgenerate
endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
   import bru_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter logic [4:0]  LINK_REG  = 5'd31,
   parameter bit          FAST_ZERO = 1'b1
) (
   input  logic [31:0] pc_i,
   input  logic [31:0] instr_i,
   input  logic [31:0] rs_val_i,
   input  logic [31:0] rt_val_i,
   output logic [31:0] next_pc_o,
   output logic        taken_o,
   output logic        link_we_o,
   output logic [4:0]  link_idx_o,
   output logic [31:0] link_addr_o
);
   localparam int DISP_W = 16;
   localparam int JIDX_W = 26;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("bru_next_pc: XLEN must be 32");
      end
      if (JIDX_W + 2 > XLEN) begin : g_bad_jidx
         $error("bru_next_pc: jump index wider than address");
      end
   endgenerate

   bru_kind_e         kind;
   bru_src_e          src;
   logic [4:0]        rd;
   logic              cond;
   logic [XLEN-1:0]   seq_a, disp_a, abs_a, reg_a;

   bru_decode u_dec (
      .instr_i (instr_i),
      .kind_o  (kind),
      .rd_o    (rd)
   );

   bru_cond #(.XLEN(XLEN), .FAST_ZERO(FAST_ZERO)) u_cond (
      .kind_i  (kind),
      .a_i     (rs_val_i),
      .b_i     (rt_val_i),
      .taken_o (cond)
   );

   bru_target #(.XLEN(XLEN), .DISP_W(DISP_W), .JIDX_W(JIDX_W)) u_tgt (
      .pc_i    (pc_i),
      .field_i (instr_i[JIDX_W-1:0]),
      .reg_i   (rs_val_i),
      .seq_o   (seq_a),
      .disp_o  (disp_a),
      .abs_o   (abs_a),
      .reg_o   (reg_a)
   );

   always_comb begin
      unique case (kind)
         K_JABS, K_JABS_LK: src = SRC_ABS;
         K_JREG, K_JREG_LK: src = SRC_REG;
         K_NONE:            src = SRC_SEQ;
         default:           src = cond ? SRC_DISP : SRC_SEQ;
      endcase
   end

   always_comb begin
      unique case (src)
         SRC_DISP: next_pc_o = disp_a;
         SRC_ABS:  next_pc_o = abs_a;
         SRC_REG:  next_pc_o = reg_a;
         default:  next_pc_o = seq_a;
      endcase
   end

   assign taken_o     = cond;
   assign link_we_o   = cond & (kind == K_LTZ_LK || kind == K_GEZ_LK ||
                                kind == K_JABS_LK || kind == K_JREG_LK);
   assign link_idx_o  = (kind == K_JREG_LK) ? rd : LINK_REG;
   assign link_addr_o = seq_a;
endmodule

// File: rtl/bru_next_pc_chk.sv
module bru_next_pc_chk (
   input logic [31:0] pc_i,
   input logic [31:0] instr_i,
   input logic [31:0] rs_val_i,
   input logic [31:0] rt_val_i,
   input logic [31:0] next_pc_o,
   input logic        taken_o,
   input logic        link_we_o,
   input logic [4:0]  link_idx_o,
   input logic [31:0] link_addr_o
);
   logic [31:0] seq;
   logic        known;
   assign seq   = pc_i + 32'd4;
   assign known = !$isunknown({pc_i, instr_i, rs_val_i, rt_val_i});

   always_comb begin
      if (known) begin
         if (!taken_o) begin
            a_r1_fallthrough: assert (next_pc_o == seq && !link_we_o)
               else $error("R1: not taken but next_pc or link wrong");
         end
         if (link_we_o) begin
            a_r8_link_needs_taken: assert (taken_o)
               else $error("R8: link write without taken");
         end
         a_r8_link_addr: assert (link_addr_o == seq)
            else $error("R8: link address not PC+4");
         if (instr_i[31:26] == 6'd1 && link_we_o) begin
            a_r5_link_r31: assert (link_idx_o == 5'd31)
               else $error("R5: and-link branch used wrong register");
         end
         if (instr_i[31:26] == 6'd2 || instr_i[31:26] == 6'd3) begin
            a_r6_region: assert (taken_o && next_pc_o[31:28] == seq[31:28]
                                 && next_pc_o[1:0] == 2'b00)
               else $error("R6: absolute jump left region");
         end
         if (instr_i[31:26] == 6'd4) begin
            a_r3_eq_follows: assert (taken_o == (rs_val_i == rt_val_i))
               else $error("R3: equality branch decision wrong");
         end
         if (instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'd8) begin
            a_r7_reg_jump: assert (taken_o && next_pc_o == rs_val_i && !link_we_o)
               else $error("R7: register jump wrong");
         end
      end
   end
endmodule

bind bru_next_pc bru_next_pc_chk u_chk (
   .pc_i        (pc_i),
   .instr_i     (instr_i),
   .rs_val_i    (rs_val_i),
   .rt_val_i    (rt_val_i),
   .next_pc_o   (next_pc_o),
   .taken_o     (taken_o),
   .link_we_o   (link_we_o),
   .link_idx_o  (link_idx_o),
   .link_addr_o (link_addr_o)
);

// File: tb/bru_next_pc_tb.sv
module bru_next_pc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc = '0, instr = '0, a = '0, b = '0;
   logic [31:0] next_pc, link_addr;
   logic        taken, link_we;
   logic [4:0]  link_idx;
   int          checks = 0, failures = 0;
   bit          done = 1'b0;

   typedef struct {
      logic [31:0] npc;
      logic        tk;
      logic        we;
      logic [4:0]  idx;
      logic [31:0] la;
      string       req;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   bru_next_pc u_dut (
      .pc_i(pc), .instr_i(instr), .rs_val_i(a), .rt_val_i(b),
      .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
      .link_idx_o(link_idx), .link_addr_o(link_addr)
   );

   function automatic logic [31:0] ii(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [15:0] imm);
      return {op, 5'd3, rt, imm};
   endfunction

   task automatic drive(input logic [31:0] i_pc, input logic [31:0] i_ins,
                        input logic [31:0] i_a, input logic [31:0] i_b,
                        input logic [31:0] e_npc, input logic e_tk,
                        input logic e_we, input logic [4:0] e_idx, input string req);
      exp_t e;
      @(negedge clk);
      pc = i_pc; instr = i_ins; a = i_a; b = i_b;
      e.npc = e_npc; e.tk = e_tk; e.we = e_we; e.idx = e_idx;
      e.la = i_pc + 32'd4; e.req = req;
      q.push_back(e);
   endtask

   always @(posedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (next_pc !== e.npc || taken !== e.tk || link_we !== e.we ||
             link_addr !== e.la || (e.we && link_idx !== e.idx)) begin
            failures++;
            $display("FAIL %s: got npc=%h tk=%b we=%b idx=%0d la=%h exp npc=%h tk=%b we=%b idx=%0d la=%h",
                     e.req, next_pc, taken, link_we, link_idx, link_addr,
                     e.npc, e.tk, e.we, e.idx, e.la);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   localparam logic [31:0] P = 32'h0040_0100;

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R1 idle word and unrecognised words fall through
      drive(P, 32'h0, 0, 0, P+4, 0, 0, 0, "R1 idle");
      drive(P, ii(6'd8, 5'd1, 16'h0010), 0, 0, P+4, 0, 0, 0, "R1 addi");
      drive(P, ii(6'd1, 5'd2, 16'h0004), 32'hFFFF_FFFF, 0, P+4, 0, 0, 0, "R1 regimm rt2");
      // R3 and R2 equality branches, offsets positive, zero, -1
      drive(P, ii(6'd4, 5'd4, 16'h0003), 5, 5, 32'h0040_0110, 1, 0, 0, "R3 beq eq");
      drive(P, ii(6'd4, 5'd4, 16'h0003), 5, 6, P+4, 0, 0, 0, "R3 beq ne");
      drive(P, ii(6'd5, 5'd4, 16'hFFFF), 5, 6, P, 1, 0, 0, "R2 bne back -1");
      drive(P, ii(6'd5, 5'd4, 16'hFFFF), 7, 7, P+4, 0, 0, 0, "R3 bne eq");
      drive(P, ii(6'd4, 5'd4, 16'h0000), 0, 0, P+4, 1, 0, 0, "R2 zero offset");
      // R4 signed zero compares, R2 extreme displacements
      drive(P, ii(6'd6, 5'd0, 16'h8000), 0, 0, 32'h003E_0104, 1, 0, 0, "R2 blez min disp");
      drive(P, ii(6'd6, 5'd0, 16'h0002), 1, 0, P+4, 0, 0, 0, "R4 blez 1");
      drive(P, ii(6'd6, 5'd0, 16'h0002), 32'h8000_0000, 0, 32'h0040_010C, 1, 0, 0, "R4 blez min");
      drive(P, ii(6'd7, 5'd0, 16'h7FFF), 1, 0, 32'h0042_0100, 1, 0, 0, "R2 bgtz max disp");
      drive(P, ii(6'd7, 5'd0, 16'h0001), 0, 0, P+4, 0, 0, 0, "R4 bgtz 0");
      drive(P, ii(6'd7, 5'd0, 16'h0001), 32'h8000_0000, 0, P+4, 0, 0, 0, "R4 bgtz min");
      drive(P, ii(6'd7, 5'd0, 16'h0001), 32'h7FFF_FFFF, 0, 32'h0040_0108, 1, 0, 0, "R4 bgtz max");
      drive(P, ii(6'd1, 5'd0, 16'h0004), 32'hFFFF_FFFF, 0, 32'h0040_0114, 1, 0, 0, "R4 bltz -1");
      drive(P, ii(6'd1, 5'd0, 16'h0004), 0, 0, P+4, 0, 0, 0, "R4 bltz 0");
      drive(P, ii(6'd1, 5'd1, 16'h0004), 0, 0, 32'h0040_0114, 1, 0, 0, "R4 bgez 0");
      drive(P, ii(6'd1, 5'd1, 16'h0004), 32'h8000_0000, 0, P+4, 0, 0, 0, "R4 bgez min");
      // R5 and-link branches
      drive(P, ii(6'd1, 5'd16, 16'h0001), 32'hFFFF_FFFF, 0, 32'h0040_0108, 1, 1, 31, "R5 bltzal taken");
      drive(P, ii(6'd1, 5'd16, 16'h0001), 5, 0, P+4, 0, 0, 0, "R5 bltzal not taken");
      drive(P, ii(6'd1, 5'd17, 16'h0001), 0, 0, 32'h0040_0108, 1, 1, 31, "R5 bgezal taken");
      drive(P, ii(6'd1, 5'd17, 16'h0001), 32'hFFFF_FFFB, 0, P+4, 0, 0, 0, "R5 bgezal not taken");
      // R6 absolute jumps, region from PC+4 crossing a 256 MB boundary
      drive(32'h9FFF_FFFC, {6'd2, 26'h012_3456}, 0, 0, 32'hA048_D158, 1, 0, 0, "R6 j region");
      drive(32'h0040_0100, {6'd3, 26'h3FF_FFFF}, 0, 0, 32'h0FFF_FFFC, 1, 1, 31, "R6 jal");
      // R7 register jumps
      drive(P, {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h0040_0200, 0, 32'h0040_0200, 1, 0, 0, "R7 jr");
      drive(P, {6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h1234_5678, 0, 32'h1234_5678, 1, 1, 7, "R7 jalr rd7");
      // R8 link address follows pc at top of address space
      drive(32'hFFFF_FFFC, {6'd3, 26'h000_0001}, 0, 0, 32'h0000_0004, 1, 1, 31, "R8 jal wrap");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule